// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces the port-to-port doorbell signals for a dual-port memory with an 11-bit address space. Two locations at the very top of the address space act as mailboxes. When one port stores a byte into the mailbox that belongs to the other port, that other port's interrupt output goes low. The interrupt stays low until the port that owns the mailbox reads it. The mailboxes remain ordinary memory words. The storage array sits beside this block and is not part of it. This block only watches the access controls and the addresses of both ports.

The right port owns the highest address (0x7FF) and the left port owns the one below it (0x7FE). The access controls are sampled on the rising edge of `clk`, and both interrupt outputs are registered. An access therefore changes an interrupt output one clock after the edge on which it is sampled. Arbitration between the ports and the open-drain output drive belong to other blocks.

Top module: `mbox_irq`

## Requirements
- R1: While `rst_n` is low at a rising edge, both `left_irq_n` and `right_irq_n` are driven high (deasserted) after that edge.
- R2: A left-port write (`left_ce_n`=0, `left_we_n`=0) to address 0x7FF drives `right_irq_n` low one clock later.
- R3: A right-port read (`right_ce_n`=0, `right_we_n`=1, `right_oe_n`=0) of address 0x7FF drives `right_irq_n` high one clock later, unless R7 applies.
- R4: A right-port write (`right_ce_n`=0, `right_we_n`=0) to address 0x7FE drives `left_irq_n` low one clock later.
- R5: A left-port read (`left_ce_n`=0, `left_we_n`=1, `left_oe_n`=0) of address 0x7FE drives `left_irq_n` high one clock later, unless R7 applies.
- R6: Accesses with chip enable high have no effect. A write with `oe_n` low still counts only as a write. A read with `oe_n` high does not clear.
- R7: If a set (R2 or R4) and a clear (R3 or R5) of the same flag fall on the same clock, the flag ends up asserted (low).
- R8: No other port/address pairing has any effect. This includes writing one's own mailbox, reading the other port's mailbox, and any address below 0x7FE.
- R9: In any clock with neither a set nor a clear for a flag, that flag's output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| left_ce_n | input | 1 | Left port chip enable, active low |
| left_we_n | input | 1 | Left port write enable, active low |
| left_oe_n | input | 1 | Left port output enable, active low |
| left_addr | input | 11 | Left port address |
| right_ce_n | input | 1 | Right port chip enable, active low |
| right_we_n | input | 1 | Right port write enable, active low |
| right_oe_n | input | 1 | Right port output enable, active low |
| right_addr | input | 11 | Right port address |
| left_irq_n | output | 1 | Interrupt toward the left port, active low |
| right_irq_n | output | 1 | Interrupt toward the right port, active low |

## Verification
The hardest case to reach is a set and a clear of the same flag in one clock while that flag is already in a chosen state. This needs a write on one port and a qualifying read on the other, both at the same mailbox address, in the same cycle. The bench gets there by sweeping every combination of starting flag state, all eight enable patterns on each port, and five addresses on each port, including both mailboxes and their neighbours. Before each sweep point it resets the block and uses real mailbox writes to put the flags into the chosen starting state. It then computes the expected outputs arithmetically from the requirements.

// File: rtl/mbox_irq_pkg.sv
// Package: shared types and mailbox placement for the mailbox interrupt block.
// Assumes the two mailboxes are the two highest words of the address space.
package mbox_irq_pkg;

    // Identifies which port a replicated slice serves.
    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    // Active-low access controls of one port.
    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } port_ctrl_t;

    // Distance below the top address of the mailbox owned by a side.
    function automatic int unsigned inbox_offset(side_e s);
        return (s == SIDE_LEFT) ? 1 : 0;
    endfunction

endpackage

// File: rtl/mbox_access_decode.sv
// Module: classifies one port's access into a mailbox post (a write to the
// peer's mailbox) and a mailbox fetch (a read of its own mailbox).
// Assumes a write takes precedence over output enable when both are low.
module mbox_access_decode
    import mbox_irq_pkg::*;
#(
    parameter int unsigned     ADDR_W    = 11,
    parameter logic [ADDR_W-1:0] POST_ADDR  = '1,
    parameter logic [ADDR_W-1:0] FETCH_ADDR = '0
) (
    input  port_ctrl_t        ctrl,
    input  logic [ADDR_W-1:0] addr,
    output logic              post_hit,
    output logic              fetch_hit
);

    logic selected;
    logic is_write;
    logic is_read;

    // Qualify the access type from the enables.
    always_comb begin
        selected = ~ctrl.ce_n;
        is_write = selected & ~ctrl.we_n;
        is_read  = selected & ctrl.we_n & ~ctrl.oe_n;
    end

    // Match the qualified access against the two mailbox words.
    always_comb begin
        post_hit  = is_write && (addr == POST_ADDR);
        fetch_hit = is_read  && (addr == FETCH_ADDR);
    end

endmodule

// File: rtl/mbox_flag.sv
// Module: one pending-interrupt bit with a set-over-clear priority and an
// active-low output. Assumes a synchronous active-low reset.
module mbox_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);

    logic pending;

    // Update the pending bit; a set beats a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (set_i)
            pending <= 1'b1;
        else if (clr_i)
            pending <= 1'b0;
    end

    // Present the pending bit as an active-low level.
    assign irq_n_o = ~pending;

endmodule

// File: rtl/mbox_irq.sv
// Module: top of the mailbox interrupt logic. Replicates one decoder and
// one flag per port; a port's flag is set by the peer's post and cleared
// by its own fetch. Assumes all inputs are synchronous to clk.
module mbox_irq
    import mbox_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              left_ce_n,
    input  logic              left_we_n,
    input  logic              left_oe_n,
    input  logic [ADDR_W-1:0] left_addr,
    input  logic              right_ce_n,
    input  logic              right_we_n,
    input  logic              right_oe_n,
    input  logic [ADDR_W-1:0] right_addr,
    output logic              left_irq_n,
    output logic              right_irq_n
);

    localparam int unsigned       NUM_SIDES = 2;
    localparam logic [ADDR_W-1:0] TOP_ADDR  = '1;

    port_ctrl_t        ctrl  [NUM_SIDES];
    logic [ADDR_W-1:0] addr  [NUM_SIDES];
    logic              post  [NUM_SIDES];
    logic              fetch [NUM_SIDES];
    logic              irq_n [NUM_SIDES];

    // Gather the per-port pins into side-indexed arrays.
    always_comb begin
        ctrl[SIDE_LEFT]  = '{ce_n: left_ce_n,  we_n: left_we_n,  oe_n: left_oe_n};
        ctrl[SIDE_RIGHT] = '{ce_n: right_ce_n, we_n: right_we_n, oe_n: right_oe_n};
        addr[SIDE_LEFT]  = left_addr;
        addr[SIDE_RIGHT] = right_addr;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam side_e OWN  = side_e'(s);
        localparam side_e PEER = side_e'(1 - s);
        localparam logic [ADDR_W-1:0] OWN_BOX  =
            TOP_ADDR - ADDR_W'(inbox_offset(OWN));
        localparam logic [ADDR_W-1:0] PEER_BOX =
            TOP_ADDR - ADDR_W'(inbox_offset(PEER));

        mbox_access_decode #(
            .ADDR_W    (ADDR_W),
            .POST_ADDR (PEER_BOX),
            .FETCH_ADDR(OWN_BOX)
        ) u_dec (
            .ctrl     (ctrl[s]),
            .addr     (addr[s]),
            .post_hit (post[s]),
            .fetch_hit(fetch[s])
        );

        mbox_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (post[PEER]),
            .clr_i  (fetch[s]),
            .irq_n_o(irq_n[s])
        );
    end

    // Drive the flag outputs from the side-indexed array.
    assign left_irq_n  = irq_n[SIDE_LEFT];
    assign right_irq_n = irq_n[SIDE_RIGHT];

endmodule

// File: rtl/mbox_irq_checker.sv
// Module: temporal checks on the mailbox interrupt ports, bound to mbox_irq.
module mbox_irq_checker #(
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              left_ce_n,
    input logic              left_we_n,
    input logic              left_oe_n,
    input logic [ADDR_W-1:0] left_addr,
    input logic              right_ce_n,
    input logic              right_we_n,
    input logic              right_oe_n,
    input logic [ADDR_W-1:0] right_addr,
    input logic              left_irq_n,
    input logic              right_irq_n
);

    localparam logic [ADDR_W-1:0] R_BOX = '1;
    localparam logic [ADDR_W-1:0] L_BOX = R_BOX - 1'b1;

    logic set_r, clr_r, set_l, clr_l;
    assign set_r = !left_ce_n  && !left_we_n  && (left_addr  == R_BOX);
    assign clr_r = !right_ce_n &&  right_we_n && !right_oe_n && (right_addr == R_BOX);
    assign set_l = !right_ce_n && !right_we_n && (right_addr == L_BOX);
    assign clr_l = !left_ce_n  &&  left_we_n  && !left_oe_n  && (left_addr  == L_BOX);

    assert_reset_idle_R1: assert property (@(posedge clk)
        (rst_n === 1'b0) |=> (left_irq_n && right_irq_n));

    assert_right_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_r |=> !right_irq_n);

    assert_right_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_r && !set_r) |=> right_irq_n);

    assert_left_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_l |=> !left_irq_n);

    assert_left_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_l && !set_l) |=> left_irq_n);

    assert_right_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_r && !clr_r) |=> $stable(right_irq_n));

    assert_left_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_l && !clr_l) |=> $stable(left_irq_n));

endmodule

bind mbox_irq mbox_irq_checker #(.ADDR_W(ADDR_W)) u_mbox_irq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .left_ce_n  (left_ce_n),
    .left_we_n  (left_we_n),
    .left_oe_n  (left_oe_n),
    .left_addr  (left_addr),
    .right_ce_n (right_ce_n),
    .right_we_n (right_we_n),
    .right_oe_n (right_oe_n),
    .right_addr (right_addr),
    .left_irq_n (left_irq_n),
    .right_irq_n(right_irq_n)
);

// File: tb/tb_mbox_irq.sv
// Bench: exhaustive sweep of start state, both ports' enables and addresses.
module tb_mbox_irq;

    localparam int ADDR_W = 11;
    localparam logic [ADDR_W-1:0] R_BOX = 11'h7FF;
    localparam logic [ADDR_W-1:0] L_BOX = 11'h7FE;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              left_ce_n = 1'b1, left_we_n = 1'b1, left_oe_n = 1'b1;
    logic              right_ce_n = 1'b1, right_we_n = 1'b1, right_oe_n = 1'b1;
    logic [ADDR_W-1:0] left_addr = '0, right_addr = '0;
    logic              left_irq_n, right_irq_n;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mbox_irq #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .left_ce_n(left_ce_n), .left_we_n(left_we_n), .left_oe_n(left_oe_n),
        .left_addr(left_addr),
        .right_ce_n(right_ce_n), .right_we_n(right_we_n), .right_oe_n(right_oe_n),
        .right_addr(right_addr),
        .left_irq_n(left_irq_n), .right_irq_n(right_irq_n)
    );

    function automatic logic [ADDR_W-1:0] pick_addr(int i);
        case (i)
            0: return R_BOX;
            1: return L_BOX;
            2: return 11'h7FD;
            3: return 11'h000;
            default: return 11'h3FF;
        endcase
    endfunction

    task automatic check(string req, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle();
        left_ce_n = 1'b1; left_we_n = 1'b1; left_oe_n = 1'b1; left_addr = '0;
        right_ce_n = 1'b1; right_we_n = 1'b1; right_oe_n = 1'b1; right_addr = '0;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int init = 0; init < 4; init++)
        for (int lc = 0; lc < 8; lc++)
        for (int rc = 0; rc < 8; rc++)
        for (int la = 0; la < 5; la++)
        for (int ra = 0; ra < 5; ra++) begin
            logic set_r, clr_r, set_l, clr_l, exp_r, exp_l;
            logic [ADDR_W-1:0] lad, rad;
            // Reset cycle
            @(negedge clk);
            rst_n = 1'b0; idle();
            @(negedge clk);
            check("R1 left", left_irq_n, 1'b1);
            check("R1 right", right_irq_n, 1'b1);
            // Prepare start state through real mailbox writes
            rst_n = 1'b1;
            if (init[0]) begin left_ce_n = 1'b0; left_we_n = 1'b0; left_addr = R_BOX; end
            if (init[1]) begin right_ce_n = 1'b0; right_we_n = 1'b0; right_addr = L_BOX; end
            @(negedge clk);
            // Stimulus cycle
            lad = pick_addr(la);
            rad = pick_addr(ra);
            left_ce_n  = lc[2]; left_we_n  = lc[1]; left_oe_n  = lc[0]; left_addr  = lad;
            right_ce_n = rc[2]; right_we_n = rc[1]; right_oe_n = rc[0]; right_addr = rad;
            set_r = !lc[2] && !lc[1] && (lad == R_BOX);
            clr_r = !rc[2] && rc[1] && !rc[0] && (rad == R_BOX);
            set_l = !rc[2] && !rc[1] && (rad == L_BOX);
            clr_l = !lc[2] && lc[1] && !lc[0] && (lad == L_BOX);
            exp_r = set_r ? 1'b0 : (clr_r ? 1'b1 : !init[0]);
            exp_l = set_l ? 1'b0 : (clr_l ? 1'b1 : !init[1]);
            @(negedge clk);
            idle();
            if (set_r && clr_r)        check("R7 right", right_irq_n, exp_r);
            else if (set_r)            check("R2 right", right_irq_n, exp_r);
            else if (clr_r)            check("R3 right", right_irq_n, exp_r);
            else if (!lc[2] || !rc[2]) check("R6 R8 right", right_irq_n, exp_r);
            else                       check("R9 right", right_irq_n, exp_r);
            if (set_l && clr_l)        check("R7 left", left_irq_n, exp_l);
            else if (set_l)            check("R4 left", left_irq_n, exp_l);
            else if (clr_l)            check("R5 left", left_irq_n, exp_l);
            else if (!lc[2] || !rc[2]) check("R6 R8 left", left_irq_n, exp_l);
            else                       check("R9 left", left_irq_n, exp_l);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule